// File: doc/BRIEF.md
# Predicated Cross-Segment Single-Precision Add Reducer

The block reduces a wide vector, viewed as a stack of 128-bit segments, into one 128-bit result. Result lane e is the floating-point sum of lane e from every segment, so the reduction runs across segments, lane by lane, not across the lanes of one segment. A governing predicate with one bit per vector byte selects which source lanes take part. A masked-off lane adds positive zero. Within each result lane the segments are combined in a fixed recursive pairwise tree: the segment list is halved, each half is reduced, and the two partial sums are added.

A single shared binary32 adder does all the work, one addition per cycle, under a three-state controller. In S_IDLE the block waits for `start_i`. An accepted single-precision request loads the masked operands and moves to S_RUN. S_RUN walks the tree for lane 0, then lane 1, and so on, and moves to S_DONE after the last lane finishes. S_DONE raises `done_o` for one cycle and returns to S_IDLE. A reserved or unsupported size code leaves the controller in S_IDLE and raises a one-cycle flag instead. The vector length `VLEN` is a parameter and must be a power-of-two multiple of 128; its default of 512 gives four segments of four lanes.

Top module: `fp_segsum_reducer`

## Requirements
- R1: A start in S_IDLE with size code 2'b00 (reserved) raises `undef_o` for exactly one cycle, starting in the cycle after the accepting edge. `done_o` stays low and `result_o` is unchanged.
- R2: A start in S_IDLE with size code 2'b01 (16-bit lanes) or 2'b11 (64-bit lanes) raises `unsup_o` for exactly one cycle. `done_o` stays low and `result_o` is unchanged.
- R3: With size code 2'b10, source lane g sits at `vec_i[32g+31:32g]` and belongs to segment g/4. Result lane e, at `result_o[32e+31:32e]`, is the binary32 sum over segments s of source lane 4s+e. The sum is grouped as (s0+s1)+(s2+s3) for four segments, and a single segment passes through unchanged.
- R4: The lane-active bit for source lane g is `pred_i[4g]`, the lowest predicate bit of its four bytes. The other predicate bits have no effect on the result. An inactive lane contributes +0.0.
- R5: When no lane is active, every result lane is 32'h00000000, whatever the vector holds, including NaN patterns.
- R6: Sums round to nearest, with ties going to the even significand.
- R7: Subnormal inputs are flushed to signed zero before use. Results below the normal range are flushed to zero carrying the sign of the exact result.
- R8: Any NaN input, or adding infinities of opposite sign, gives 32'h7FC00000. Overflow gives an infinity of the result's sign.
- R9: (+0)+(-0) gives +0, and (-0)+(-0) gives -0.
- R10: `done_o` is high for exactly one cycle. It first reads high 4*max(NSEG-1,1) cycles after the accepting edge, which is 12 cycles at the default size. `done_o`, `undef_o` and `unsup_o` are never high together.
- R11: `start_i` is ignored while a reduction is in progress. Such a start raises no flag and does not disturb the running reduction or its timing.
- R12: `result_o` holds its value from the end of one reduction until the next accepted single-precision start, regardless of input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, sampled in S_IDLE |
| size_i | input | 2 | Lane-size code: 00 reserved, 01 half, 10 single, 11 double |
| vec_i | input | VLEN | Source vector, segment 0 in the low 128 bits |
| pred_i | input | VLEN/8 | Governing predicate, one bit per byte |
| result_o | output | 128 | Four binary32 lane sums |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | One-cycle reserved-encoding flag |
| unsup_o | output | 1 | One-cycle unsupported-size flag |

## Verification
The assertions check the following on every cycle: the controller's pulse discipline, the cause of each flag, and that starts arriving in S_RUN or S_DONE raise nothing. They also check that the result register moves only in S_RUN, that the shared adder always answers a NaN operand with the default NaN, and that it never emits a subnormal.

Only the bench scenarios can show the numeric content. That covers the transposed lane mapping and the pairwise grouping order, seen through a case whose rounding depends on grouping. It also covers tie-to-even and round-up cases, flushes, overflow, signed zeros, and the all-inactive rule. The bench sweeps all sixteen segment-activity patterns and then random per-lane predicates, with garbage in the ignored predicate bits.

// File: rtl/fpred_pkg.sv
package fpred_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } red_state_t;

    localparam logic [1:0]  SZ_RSVD   = 2'b00;
    localparam logic [1:0]  SZ_SINGLE = 2'b10;
    localparam logic [31:0] FP_QNAN   = 32'h7FC0_0000;
    localparam int          FP_W      = 32;
    localparam int          SEG_BITS  = 128;
endpackage

// File: rtl/fpred_fp32_add.sv
module fpred_fp32_add
    import fpred_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic [31:0] sum_o
);
    logic        sa, sb;
    logic [7:0]  ea, eb;
    logic [22:0] fa, fb;
    logic        a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

    assign {sa, ea, fa} = op_a;
    assign {sb, eb, fb} = op_b;
    assign a_nan  = (ea == 8'hFF) && (fa != 23'd0);
    assign b_nan  = (eb == 8'hFF) && (fb != 23'd0);
    assign a_inf  = (ea == 8'hFF) && (fa == 23'd0);
    assign b_inf  = (eb == 8'hFF) && (fb == 23'd0);
    assign a_zero = (ea == 8'd0);   // subnormals flushed
    assign b_zero = (eb == 8'd0);

    logic              swap, sg, found, rup;
    logic [7:0]        e_big, e_sml, dexp;
    logic [26:0]       m_big, m_sml, m_al, m_df, norm;
    logic [27:0]       s28;
    logic [4:0]        lz;
    logic signed [9:0] ex;
    logic [24:0]       m25;
    logic [31:0]       gen;

    always_comb begin
        swap  = {eb, fb} > {ea, fa};
        sg    = swap ? sb : sa;
        e_big = swap ? eb : ea;
        e_sml = swap ? ea : eb;
        m_big = {1'b1, (swap ? fb : fa), 3'b000};
        m_sml = {1'b1, (swap ? fa : fb), 3'b000};
        dexp  = e_big - e_sml;
        if (dexp >= 8'd27)
            m_al = 27'd1;
        else
            m_al = (m_sml >> dexp) | {26'd0, |(m_sml & ((27'd1 << dexp) - 27'd1))};
        s28  = {1'b0, m_big} + {1'b0, m_al};
        m_df = m_big - m_al;
        lz    = 5'd0;
        found = 1'b0;
        for (int i = 26; i >= 0; i--) begin
            if (!found) begin
                if (m_df[i]) found = 1'b1;
                else         lz    = lz + 5'd1;
            end
        end
        if (sa == sb) begin
            if (s28[27]) begin
                norm = {s28[27:2], s28[1] | s28[0]};
                ex   = $signed({2'b00, e_big}) + 10'sd1;
            end else begin
                norm = s28[26:0];
                ex   = $signed({2'b00, e_big});
            end
        end else begin
            norm = m_df << lz;
            ex   = $signed({2'b00, e_big}) - $signed({5'd0, lz});
        end
        rup = norm[2] & (norm[1] | norm[0] | norm[3]);
        m25 = {1'b0, norm[26:3]} + {24'd0, rup};
        if (m25[24]) ex = ex + 10'sd1;
        if ((sa != sb) && (m_df == 27'd0))
            gen = 32'h0000_0000;
        else if (ex <= 10'sd0)
            gen = {sg, 31'd0};
        else if (ex >= 10'sd255)
            gen = {sg, 8'hFF, 23'd0};
        else
            gen = {sg, ex[7:0], (m25[24] ? 23'd0 : m25[22:0])};

        if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) sum_o = FP_QNAN;
        else if (a_inf)             sum_o = op_a;
        else if (b_inf)             sum_o = op_b;
        else if (a_zero && b_zero)  sum_o = {sa & sb, 31'd0};
        else if (a_zero)            sum_o = op_b;
        else if (b_zero)            sum_o = op_a;
        else                        sum_o = gen;
    end
endmodule

// File: rtl/fpred_pred_mask.sv
module fpred_pred_mask
    import fpred_pkg::*;
#(
    parameter int NLANE = 16
) (
    input  logic [NLANE*FP_W-1:0] vec_i,
    input  logic [NLANE*4-1:0]    pred_i,
    output logic [NLANE*FP_W-1:0] masked_o
);
    logic [NLANE-1:0] lane_act;
    logic             any_act;
    logic             pred_unused;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_act[g] = pred_i[4*g];
        assign masked_o[FP_W*g +: FP_W] =
            (any_act && lane_act[g]) ? vec_i[FP_W*g +: FP_W] : {FP_W{1'b0}};
    end

    assign any_act     = |lane_act;
    assign pred_unused = ^pred_i;
endmodule

// File: rtl/fp_segsum_reducer.sv
module fp_segsum_reducer
    import fpred_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [VLEN-1:0]   vec_i,
    input  logic [VLEN/8-1:0] pred_i,
    output logic [127:0]      result_o,
    output logic              done_o,
    output logic              undef_o,
    output logic              unsup_o
);
    localparam int NSEG   = VLEN / SEG_BITS;
    localparam int LPS    = SEG_BITS / FP_W;
    localparam int NLANE  = NSEG * LPS;
    localparam int SIW    = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int PIW    = SIW + 2;
    localparam int PDEPTH = 1 << PIW;

    red_state_t       state_q, state_d;
    logic [VLEN-1:0]  masked;
    logic [31:0]      part_q [PDEPTH];
    logic [1:0]       lane_q;
    logic [SIW:0]     idx_q, strd_q, idx_n;
    logic [SIW-1:0]   seg_b;
    logic [PIW-1:0]   ia, ib;
    logic [31:0]      add_a, add_b, add_y, wval;
    logic [127:0]     result_q;
    logic             undef_q, unsup_q, last_step, accept;

    fpred_pred_mask #(.NLANE(NLANE)) u_mask (
        .vec_i    (vec_i),
        .pred_i   (pred_i),
        .masked_o (masked)
    );

    fpred_fp32_add u_add (
        .op_a  (add_a),
        .op_b  (add_b),
        .sum_o (add_y)
    );

    assign accept    = (state_q == S_IDLE) && start_i && (size_i == SZ_SINGLE);
    assign seg_b     = idx_q[SIW-1:0] + strd_q[SIW-1:0];
    assign ia        = {idx_q[SIW-1:0], lane_q};
    assign ib        = {seg_b, lane_q};
    assign idx_n     = idx_q + (strd_q << 1);
    assign add_a     = part_q[ia];
    assign add_b     = part_q[ib];
    assign wval      = (NSEG == 1) ? add_a : add_y;
    assign last_step = (NSEG == 1) || (strd_q == (SIW+1)'(NSEG / 2));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_RUN;
            S_RUN:   if (last_step && (lane_q == 2'd3)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // operand scratch: loaded on accept, overwritten by partial sums
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int g = 0; g < NLANE; g++)
                part_q[g] <= masked[FP_W*g +: FP_W];
        end else if ((state_q == S_RUN) && (NSEG > 1)) begin
            part_q[ia] <= add_y;
        end
    end

    // tree walk counters, result, flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            lane_q   <= '0;
            idx_q    <= '0;
            strd_q   <= (SIW+1)'(1);
            undef_q  <= 1'b0;
            unsup_q  <= 1'b0;
        end else begin
            undef_q <= 1'b0;
            unsup_q <= 1'b0;
            if (state_q == S_IDLE && start_i) begin
                if (size_i == SZ_RSVD)        undef_q <= 1'b1;
                else if (size_i != SZ_SINGLE) unsup_q <= 1'b1;
                lane_q <= '0;
                idx_q  <= '0;
                strd_q <= (SIW+1)'(1);
            end else if (state_q == S_RUN) begin
                if (last_step) begin
                    result_q[FP_W*lane_q +: FP_W] <= wval;
                    lane_q <= lane_q + 2'd1;
                    idx_q  <= '0;
                    strd_q <= (SIW+1)'(1);
                end else if (idx_n >= (SIW+1)'(NSEG)) begin
                    idx_q  <= '0;
                    strd_q <= strd_q << 1;
                end else begin
                    idx_q  <= idx_n;
                end
            end
        end
    end

    // outputs
    always_comb begin
        done_o   = (state_q == S_DONE);
        undef_o  = undef_q;
        unsup_o  = unsup_q;
        result_o = result_q;
    end

    p_undef_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> $past(start_i && (size_i == SZ_RSVD) && (state_q == S_IDLE)));
    p_unsup_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> $past(start_i && (size_i[0] == 1'b1) && (state_q == S_IDLE)));
    p_default_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RUN) && (NSEG > 1) && (add_a[30:23] == 8'hFF) && (add_a[22:0] != 23'd0))
        |-> (add_y == FP_QNAN));
    p_no_subnormal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RUN) && (add_y[30:23] == 8'd0)) |-> (add_y[22:0] == 23'd0));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, undef_o, unsup_o}));
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (!undef_o && !unsup_o));
    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_RUN) |=> $stable(result_o));
endmodule

// File: tb/fp_segsum_reducer_bench.sv
`timescale 1ns/1ps
module fp_segsum_reducer_bench;
    localparam int VLEN = 512;
    localparam int NL   = 16;
    localparam int LAT  = 12;

    logic              clk = 1'b0;
    logic              rst_n, start_i;
    logic [1:0]        size_i;
    logic [VLEN-1:0]   vec_i;
    logic [VLEN/8-1:0] pred_i;
    logic [127:0]      result_o;
    logic              done_o, undef_o, unsup_o;

    always #2.5 clk = ~clk;

    fp_segsum_reducer #(.VLEN(VLEN)) u_fp_segsum_reducer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .vec_i(vec_i), .pred_i(pred_i), .result_o(result_o),
        .done_o(done_o), .undef_o(undef_o), .unsup_o(unsup_o)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int unsigned seed  = 32'h1357_9BDF;
    logic [31:0] w  [NL];
    bit          act[NL];
    int          v  [NL];
    logic [31:0] ex [4];
    bit          junk;
    logic [127:0] held;

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [31:0] f32i(input int k);
        int m;
        int p;
        if (k == 0) return 32'h0;
        m = (k < 0) ? -k : k;
        p = 0;
        for (int i = 0; i < 24; i++) if (((m >> i) & 1) != 0) p = i;
        return {(k < 0), 8'(127 + p), 23'((m << (23 - p)) & 32'h7F_FFFF)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_op();
        for (int g = 0; g < NL; g++) begin
            w[g] = 32'h0; act[g] = 1'b1; v[g] = 0;
        end
        junk = 1'b0;
    endtask

    task automatic drive_inputs();
        for (int g = 0; g < NL; g++) begin
            int unsigned r;
            r = rnd();
            vec_i[32*g +: 32] = w[g];
            pred_i[4*g]       = act[g];
            for (int b = 1; b < 4; b++) pred_i[4*g+b] = junk ? r[b] : 1'b0;
        end
    endtask

    task automatic run32(input string tag);
        int cnt;
        @(negedge clk);
        drive_inputs();
        size_i = 2'b10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LAT, {"R10 latency ", tag}, cnt, LAT);
        @(negedge clk);
        chk(done_o == 1'b0, {"R10 one-cycle done ", tag}, {31'd0, done_o}, 32'd0);
    endtask

    task automatic check_lanes(input string tag);
        for (int e = 0; e < 4; e++)
            chk(result_o[32*e +: 32] == ex[e], tag, result_o[32*e +: 32], ex[e]);
    endtask

    task automatic expect_int_sums();
        for (int e = 0; e < 4; e++) begin
            int acc;
            acc = 0;
            for (int s = 0; s < 4; s++) if (act[4*s+e]) acc += v[4*s+e];
            ex[e] = f32i(acc);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; size_i = 2'b10; vec_i = '0; pred_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result_o == 128'd0, "reset result", result_o[31:0], 32'd0);
        chk({done_o, undef_o, unsup_o} == 3'b000, "reset flags R10",
            {29'd0, done_o, undef_o, unsup_o}, 32'd0);

        // R3 R4: all 16 segment-activity patterns, then random per-lane predicates
        for (int t = 0; t < 40; t++) begin
            clear_op();
            junk = (t % 2) == 1;
            for (int g = 0; g < NL; g++) begin
                int unsigned r;
                r = rnd();
                v[g]   = (int'(r % 201) - 100) <<< ((t % 4) * 3);
                act[g] = (t < 16) ? (((t >> (g / 4)) & 1) != 0) : r[20];
                w[g]   = f32i(v[g]);
            end
            expect_int_sums();
            run32("R3 R4 sweep");
            check_lanes(junk ? "R4 ignored predicate bits" : "R3 lane sums");
        end

        // R5: nothing active, NaN patterns in the data
        clear_op();
        for (int g = 0; g < NL; g++) begin
            w[g] = (g % 2 == 0) ? 32'h7FA0_0000 : 32'h4120_0000; act[g] = 1'b0;
        end
        junk = 1'b1;
        for (int e = 0; e < 4; e++) ex[e] = 32'h0;
        run32("R5");
        check_lanes("R5 all inactive gives +0");

        // R6: rounding, lane e source at 4s+e
        clear_op();
        w[0] = 32'h4B80_0000; w[4] = 32'h3F80_0000; ex[0] = 32'h4B80_0000;
        w[1] = 32'h4B80_0000; w[5] = 32'h4040_0000; ex[1] = 32'h4B80_0002;
        w[2] = 32'h4B80_0000; w[6] = 32'h4020_0000; ex[2] = 32'h4B80_0001;
        w[3] = 32'h4B80_0001; w[7] = 32'hBF80_0000; ex[3] = 32'h4B80_0000;
        run32("R6");
        check_lanes("R6 round nearest even");

        // R3: grouping order (s0+s1)+(s2+s3) is visible through rounding
        clear_op();
        w[0] = 32'h4B80_0000; w[4] = 32'h3F80_0000; w[8] = 32'h0; w[12] = 32'h3F80_0000;
        ex[0] = 32'h4B80_0000; ex[1] = 32'h0; ex[2] = 32'h0; ex[3] = 32'h0;
        run32("R3 order");
        check_lanes("R3 pairwise grouping");

        // R8 R4 R7: NaN, inf-inf, inactive NaN, subnormal inputs
        clear_op();
        w[0] = 32'h3F80_0000; w[4] = 32'h3F80_0000; w[8] = 32'h7FA0_0000; w[12] = 32'h3F80_0000;
        w[1] = 32'h7F80_0000; w[13] = 32'hFF80_0000;
        w[2] = 32'h4000_0000; w[6] = 32'h7FA0_0000; act[6] = 1'b0;
        w[10] = 32'h4000_0000; w[14] = 32'h4000_0000;
        w[3] = 32'h1; w[7] = 32'h1; w[11] = 32'h1; w[15] = 32'h1;
        ex[0] = 32'h7FC0_0000; ex[1] = 32'h7FC0_0000; ex[2] = 32'h40C0_0000; ex[3] = 32'h0;
        run32("R8");
        check_lanes("R8 R4 R7 specials");

        // R9 R8 R7: signed zeros, overflow, underflowing difference
        clear_op();
        w[0] = 32'h8000_0000; w[4] = 32'h8000_0000; w[8] = 32'h8000_0000; w[12] = 32'h8000_0000;
        w[1] = 32'h8000_0000; w[5] = 32'h8000_0000;
        w[2] = 32'h7F7F_FFFF; w[6] = 32'h7F7F_FFFF;
        w[3] = 32'h0080_0001; w[7] = 32'h8080_0000;
        ex[0] = 32'h8000_0000; ex[1] = 32'h0; ex[2] = 32'h7F80_0000; ex[3] = 32'h0;
        run32("R9");
        check_lanes("R9 R8 R7 zeros and overflow");

        // R11: starts while busy are ignored
        clear_op();
        for (int g = 0; g < NL; g++) begin v[g] = g + 1; w[g] = f32i(v[g]); end
        expect_int_sums();
        begin
            int cnt;
            @(negedge clk);
            drive_inputs(); size_i = 2'b10; start_i = 1'b1;
            @(negedge clk);
            cnt = 0;
            for (int k = 0; k < 4; k++) begin
                vec_i = '1; size_i = (k % 2 == 0) ? 2'b00 : 2'b01; start_i = 1'b1;
                @(negedge clk);
                cnt++;
                chk(!undef_o && !unsup_o, "R11 busy start raises no flag",
                    {30'd0, undef_o, unsup_o}, 32'd0);
            end
            start_i = 1'b0; size_i = 2'b10;
            while (!done_o && cnt < 200) begin @(negedge clk); cnt++; end
            chk(cnt == LAT, "R11 latency unchanged", cnt, LAT);
            check_lanes("R11 result of first request");
        end

        // R12: hold under input activity
        held = result_o;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            vec_i = {16{32'h4000_0000}}; pred_i = '1;
        end
        chk(result_o == held, "R12 result held", result_o[31:0], held[31:0]);

        // R1: reserved size code
        @(negedge clk); size_i = 2'b00; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(undef_o && !done_o && !unsup_o, "R1 undef raised",
            {29'd0, undef_o, done_o, unsup_o}, 32'd4);
        @(negedge clk);
        chk(!undef_o && !done_o, "R1 undef one cycle", {30'd0, undef_o, done_o}, 32'd0);
        chk(result_o == held, "R1 result unchanged", result_o[31:0], held[31:0]);

        // R2: half and double unsupported
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); size_i = (k == 0) ? 2'b01 : 2'b11; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            chk(unsup_o && !done_o && !undef_o, "R2 unsup raised",
                {29'd0, unsup_o, done_o, undef_o}, 32'd4);
            @(negedge clk);
            chk(!unsup_o && !done_o, "R2 unsup one cycle", {30'd0, unsup_o, done_o}, 32'd0);
            chk(result_o == held, "R2 result unchanged", result_o[31:0], held[31:0]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule